// File: doc/BRIEF.md
# Relocatable ISA I/O Port Decoder

This block sits between a PC ISA bus and a small peripheral. It watches a 10-bit I/O address, the address-enable line and the read and write command lines. It turns each qualifying bus cycle into one of four single-clock strobes: data read, data write, status read or control write. The peripheral occupies one even/odd pair of I/O addresses. Address bit 0 chooses between the data port and the control/status port.

After a master reset the pair sits at a base taken from a 4-bit strap through a parameterised lookup table. Software can move the pair once with a two-write sequence. First it writes the low byte of the new address to the even port. Then it writes an unlock byte, carrying the two top address bits, to the odd port. From then on the block answers only at the new pair, and only another master reset brings back the strap-selected base. The command lines are sampled in the system clock domain, and each strobe is a registered pulse raised by the falling edge of a command line.

Top module: `isa_port_decoder`

## Requirements
- R1: While `rst_n` is low and after its release, all four strobes are low. The block starts in strap-selected mode.
- R2: A read at the even address of the active pair pulses `rd_data_stb`. A read at the odd address pulses `rd_stat_stb`. With the default table, strap 4'b0001 selects base 10'h2E0.
- R3: A write at the even address pulses `wr_data_stb`. A write at the odd address pulses `wr_ctrl_stb`, unless it is the unlock write of R8.
- R4: An access is recognised only when `aen_n` is low and exactly one of `ior_n`/`iow_n` is low. With `aen_n` high, or with both command lines low, no strobe occurs.
- R5: Addresses outside the active pair (all 10 bits compared except bit 0) produce no strobe.
- R6: A strobe is high for exactly one clock. It appears in the cycle after the clock edge that first samples the command line low. A command held low for several cycles gives one pulse, and at most one strobe is high at a time.
- R7: In strap-selected mode, strap value 4'b0000 disables decoding entirely.
- R8: In strap-selected mode, a write to the even port stores the data byte as a pending low address. A later write to the odd port whose bits 7:2 equal 6'b010101 moves the pair to base {data[1:0], pending[7:1], 1'b0}. Pending bit 0 is ignored. This unlock write gives no strobe, and afterwards the old pair is ignored. Example: A5h to 2E0h, then 57h to 2E1h, moves the pair to 3A4h/3A5h.
- R9: Once relocated, an odd-port write carrying the unlock pattern is an ordinary control write and does not move the pair. The strap input has no effect.
- R10: A master reset returns the block to strap-selected mode at the strap base.
- R11: In strap-selected mode, an odd-port write whose bits 7:2 differ from 6'b010101 is an ordinary control write and leaves the base unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Master reset, active low |
| strap | input | 4 | Base-address strap selector |
| addr | input | 10 | ISA I/O address |
| wdata | input | 8 | ISA data byte during writes |
| aen_n | input | 1 | Address enable, active low |
| ior_n | input | 1 | I/O read command, active low |
| iow_n | input | 1 | I/O write command, active low |
| rd_data_stb | output | 1 | Data port read pulse |
| wr_data_stb | output | 1 | Data port write pulse |
| rd_stat_stb | output | 1 | Status port read pulse |
| wr_ctrl_stb | output | 1 | Control port write pulse |

## Verification
The mode flag, the relocated base and the pending byte are visible only through which address pair produces strobes. A corrupt base shows as a missing strobe on the first access to the expected pair and a stray strobe at the wrong one, one clock after the command edge. A wrongly set mode flag shows as an unlock write that relocates twice, or as a strap change that still moves the pair. A stale pending byte shows when the relocated even port stays silent.

// File: rtl/isa_port_decoder.sv
module isa_port_decoder #(
  parameter int AW = 10,
  parameter int DW = 8,
  parameter logic [DW-AW+DW-1:0] UNLOCK_KEY = 6'b010101,
  parameter logic [16*AW-1:0] STRAP_MAP = {
    10'h3D0, 10'h3C0, 10'h3B0, 10'h3A0, 10'h390, 10'h380, 10'h370, 10'h360,
    10'h350, 10'h340, 10'h330, 10'h320, 10'h310, 10'h300, 10'h2E0, 10'h000}
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [3:0]    strap,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  input  logic          aen_n,
  input  logic          ior_n,
  input  logic          iow_n,
  output logic          rd_data_stb,
  output logic          wr_data_stb,
  output logic          rd_stat_stb,
  output logic          wr_ctrl_stb
);
  localparam int HI = AW - DW;

  logic          ior_q, iow_q, sw_mode;
  logic [AW-1:0] sw_base;
  logic [DW-1:0] pending;

  wire [AW-1:0] hw_base = STRAP_MAP[int'(strap)*AW +: AW];
  wire          hw_en   = (strap != 4'd0);
  wire [AW-1:0] base    = sw_mode ? sw_base : hw_base;
  wire          hit     = (sw_mode || hw_en) && (addr[AW-1:1] == base[AW-1:1]);
  wire          cyc_ok  = !aen_n && (ior_n ^ iow_n);
  wire          rd_go   = cyc_ok && ior_q && !ior_n && hit;
  wire          wr_go   = cyc_ok && iow_q && !iow_n && hit;
  wire          key_ok  = (wdata[DW-1:HI] == UNLOCK_KEY);
  wire          commit  = wr_go && addr[0] && !sw_mode && key_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ior_q       <= 1'b1;
      iow_q       <= 1'b1;
      sw_mode     <= 1'b0;
      sw_base     <= '0;
      pending     <= '0;
      rd_data_stb <= 1'b0;
      wr_data_stb <= 1'b0;
      rd_stat_stb <= 1'b0;
      wr_ctrl_stb <= 1'b0;
    end else begin
      ior_q       <= ior_n;
      iow_q       <= iow_n;
      rd_data_stb <= rd_go && !addr[0];
      rd_stat_stb <= rd_go && addr[0];
      wr_data_stb <= wr_go && !addr[0];
      wr_ctrl_stb <= wr_go && addr[0] && !commit;
      if (wr_go && !addr[0] && !sw_mode)
        pending <= wdata;
      if (commit) begin
        sw_mode <= 1'b1;
        sw_base <= {wdata[HI-1:0], pending[DW-1:1], 1'b0};
      end
    end
  end

  wire [3:0] stbs = {wr_ctrl_stb, rd_stat_stb, wr_data_stb, rd_data_stb};

  AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(stbs)); // R6
  AST_RD_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data_stb || rd_stat_stb) |=> !(rd_data_stb || rd_stat_stb)); // R6
  AST_WR_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_data_stb || wr_ctrl_stb) |=> !(wr_data_stb || wr_ctrl_stb)); // R6
  AST_NEED_AEN: assert property (@(posedge clk) disable iff (!rst_n)
    (|stbs) |-> $past(!aen_n)); // R4
  AST_NOT_BOTH: assert property (@(posedge clk) disable iff (!rst_n)
    (|stbs) |-> $past(ior_n ^ iow_n)); // R4
  AST_STRAP_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (!sw_mode && $past(strap == 4'd0) && $past(!sw_mode)) |-> !(|stbs)); // R7
  AST_MODE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    sw_mode |=> sw_mode); // R9
  AST_UNLOCK_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sw_mode) |-> !(|stbs)); // R8
endmodule

// File: tb/isa_port_decoder_bench.sv
module isa_port_decoder_bench;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] strap = 4'd1;
  logic [9:0] addr = '0;
  logic [7:0] wdata = '0;
  logic       aen_n = 1'b1, ior_n = 1'b1, iow_n = 1'b1;
  logic       rd_data_stb, wr_data_stb, rd_stat_stb, wr_ctrl_stb;

  int checks = 0, errors = 0;
  time        due_q[$];
  logic [3:0] code_q[$];
  string      tag_q[$];

  localparam logic [3:0] NONE = 4'b0000, RDD = 4'b0001, WRD = 4'b0010,
                         RDS = 4'b0100, WRC = 4'b1000;

  always #(CLK_PERIOD/2) clk = ~clk;

  isa_port_decoder u_isa_port_decoder (
    .clk(clk), .rst_n(rst_n), .strap(strap), .addr(addr), .wdata(wdata),
    .aen_n(aen_n), .ior_n(ior_n), .iow_n(iow_n),
    .rd_data_stb(rd_data_stb), .wr_data_stb(wr_data_stb),
    .rd_stat_stb(rd_stat_stb), .wr_ctrl_stb(wr_ctrl_stb));

  wire [3:0] got = {wr_ctrl_stb, rd_stat_stb, wr_data_stb, rd_data_stb};

  task automatic check(input logic [3:0] act, input logic [3:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: strobes actual %b expected %b at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    #1;
    while (due_q.size() > 0 && due_q[0] <= $time - 1) begin
      void'(due_q.pop_front());
      check(got, code_q.pop_front(), tag_q.pop_front());
    end
  end

  task automatic cyc(input logic r, input logic w, input logic aen, input logic [9:0] a,
                     input logic [7:0] d, input logic [3:0] exp, input string tag);
    @(negedge clk);
    ior_n = r; iow_n = w; aen_n = aen; addr = a; wdata = d;
    due_q.push_back($time + CLK_PERIOD);
    code_q.push_back(exp);
    tag_q.push_back(tag);
  endtask

  task automatic access(input logic is_rd, input logic both, input logic aen,
                        input logic [9:0] a, input logic [7:0] d,
                        input logic [3:0] exp, input string tag);
    logic r, w;
    r = !(is_rd || both);
    w = !(!is_rd || both);
    cyc(1'b1, 1'b1, aen, a, d, NONE, tag);
    cyc(r, w, aen, a, d, exp, tag);
    cyc(r, w, aen, a, d, NONE, {tag, " single pulse R6"});
    cyc(1'b1, 1'b1, 1'b1, a, d, NONE, tag);
  endtask

  task automatic do_reset(input string tag);
    @(negedge clk);
    rst_n = 1'b0; ior_n = 1'b1; iow_n = 1'b1; aen_n = 1'b1;
    @(negedge clk); #1;
    check(got, NONE, {tag, " in reset"});
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk); #2;
    check(got, NONE, {tag, " after reset"});
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual running expected finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    do_reset("R1");
    access(1, 0, 0, 10'h2E0, 8'h00, RDD, "R2 even read");
    access(1, 0, 0, 10'h2E1, 8'h00, RDS, "R2 odd read");
    access(0, 0, 0, 10'h2E0, 8'h12, WRD, "R3 even write");
    access(0, 0, 0, 10'h2E1, 8'h33, WRC, "R3 R11 odd non-key write");
    access(1, 0, 0, 10'h2E0, 8'h00, RDD, "R11 base kept");
    access(1, 0, 1, 10'h2E0, 8'h00, NONE, "R4 aen high");
    access(1, 1, 0, 10'h2E0, 8'h00, NONE, "R4 both low");
    access(0, 1, 0, 10'h2E1, 8'h57, NONE, "R4 both low no unlock");
    access(1, 0, 0, 10'h2E2, 8'h00, NONE, "R5 neighbour address");
    access(0, 0, 0, 10'h0E1, 8'h57, NONE, "R5 upper bits differ");
    @(negedge clk); strap = 4'd0;
    access(1, 0, 0, 10'h2E0, 8'h00, NONE, "R7 strap zero");
    access(0, 0, 0, 10'h000, 8'h00, NONE, "R7 strap zero addr 0");
    @(negedge clk); strap = 4'd1;
    access(0, 0, 0, 10'h2E0, 8'hA5, WRD, "R8 load pending");
    access(0, 0, 0, 10'h2E1, 8'h57, NONE, "R8 unlock write");
    access(1, 0, 0, 10'h3A4, 8'h00, RDD, "R8 new even read");
    access(0, 0, 0, 10'h3A5, 8'h11, WRC, "R8 new odd write");
    access(1, 0, 0, 10'h2E0, 8'h00, NONE, "R8 old pair ignored");
    access(0, 0, 0, 10'h3A5, 8'h54, WRC, "R9 key is control write");
    access(0, 0, 0, 10'h3A4, 8'h10, WRD, "R9 even write");
    access(1, 0, 0, 10'h3A5, 8'h00, RDS, "R9 pair unchanged");
    access(1, 0, 0, 10'h010, 8'h00, NONE, "R9 no second move");
    @(negedge clk); strap = 4'd2;
    access(1, 0, 0, 10'h3A4, 8'h00, RDD, "R9 strap ignored");
    access(1, 0, 0, 10'h300, 8'h00, NONE, "R9 strap base ignored");
    @(negedge clk); strap = 4'd1;
    repeat (2) @(negedge clk);
    do_reset("R10 R1");
    access(1, 0, 0, 10'h3A4, 8'h00, NONE, "R10 relocated pair gone");
    access(1, 0, 0, 10'h2E0, 8'h00, RDD, "R10 strap base back");
    repeat (3) @(negedge clk);
    #2;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule